// File: doc/BRIEF.md
# Grouped In-Order Dispatch Controller

This block sits between a queue of decoded instructions and the issue schedulers of an out-of-order core. Each cycle it looks at a window of the oldest waiting instructions and grants the longest in-order prefix that fits in one dispatch group. A grant needs room in every resource at once: group width measured in micro-ops, reorder-buffer entries, physical rename registers, one slot in the chosen scheduler, and a load-queue or store-queue slot when the instruction is a memory access. Credits for these resources come back through per-cycle release inputs from retire and issue.

The upstream queue pops as many entries as there are asserted grant bits. Whenever the window holds a valid instruction that is left waiting, the cycle is counted as a stall and charged to exactly one cause. A histogram counts, for every cycle, how many micro-ops were dispatched in that cycle.

Top module: `dispatch_stage`

## Requirements
- R1: Lane 0 of the window holds the oldest instruction. A lane is granted only when it is valid and every older lane in the window is granted, so the grants always form a prefix starting at lane 0.
- R2: The effective group width W is `DISP_W`, or `DEF_W` when `DISP_W` is 0. The window has W lanes. An instruction joins a non-empty group only if the group's micro-op total stays at or below W after it is added.
- R3: An instruction needs as many free reorder-buffer entries as it has micro-ops (`in_uops` field, 1 or more), counted cumulatively over the group.
- R4: An instruction needs as many free physical registers as its destination count (`in_dsts` field), counted cumulatively over the group. With `REG_LIMIT` = 0 the register count is unbounded and never blocks.
- R5: An instruction takes one entry in the scheduler named by its `in_sched` field (lane i uses bits [i*SCH_IDW +: SCH_IDW]). It is blocked when that scheduler has no entry left after the older grants in the same group.
- R6: An instruction flagged `in_load` needs one load-queue entry and one flagged `in_store` needs one store-queue entry, both counted cumulatively over the group.
- R7: Every credit pool starts full at reset. Each cycle a pool becomes: free count minus the amount granted this cycle plus the release input. A release therefore becomes usable in the following cycle.
- R8: An instruction whose micro-op count exceeds W is still granted when it is the first of an empty group and all its other resources are available.
- R9: A cycle in which a valid lane is not granted is a stall cycle. Exactly one stall counter is incremented, chosen from the first blocked lane using the order register, reorder buffer, scheduler, load queue, store queue, group width.
- R10: Every cycle increments exactly one histogram bin. The bin index is the number of dispatched micro-ops, saturated at W. Bin b occupies `hist_cnt[b*CNT_W +: CNT_W]`.
- R11: Reset clears all stall counters and histogram bins to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | LANES | Window lane holds an instruction |
| in_uops | input | LANES*UOP_W | Micro-op count per lane |
| in_dsts | input | LANES*DST_W | Destination register count per lane |
| in_sched | input | LANES*SCH_IDW | Target scheduler index per lane |
| in_load | input | LANES | Lane instruction needs a load-queue entry |
| in_store | input | LANES | Lane instruction needs a store-queue entry |
| rob_release | input | ROB_FW | Reorder-buffer entries freed by retire this cycle |
| reg_release | input | REG_FW | Physical registers freed by retire this cycle |
| sched_release | input | NUM_SCHED | One entry freed per scheduler by issue this cycle |
| lq_release | input | 1 | One load-queue entry freed |
| sq_release | input | 1 | One store-queue entry freed |
| disp_valid | output | LANES | Per-lane grant, an in-order prefix |
| stall_reg_cnt | output | CNT_W | Stall cycles charged to registers |
| stall_rob_cnt | output | CNT_W | Stall cycles charged to the reorder buffer |
| stall_sched_cnt | output | CNT_W | Stall cycles charged to a full scheduler |
| stall_lq_cnt | output | CNT_W | Stall cycles charged to the load queue |
| stall_sq_cnt | output | CNT_W | Stall cycles charged to the store queue |
| stall_group_cnt | output | CNT_W | Stall cycles charged to group width |
| hist_cnt | output | (LANES+1)*CNT_W | Per-cycle dispatched micro-op histogram |

## Verification
The main instance is built with `DISP_W` = 0, so the default width of 2 is in force. Its pools are deliberately tiny: 6 reorder-buffer entries, 4 registers, two schedulers of 2 entries each, a 2-entry load queue and a 1-entry store queue. With pools this small, every stall cause and every combination of causes in one cycle occurs within a few thousand cycles of randomized traffic, and each grant and counter is compared with an arithmetic model. A 3-micro-op instruction exceeds the width and exercises the lone-oversize rule. A second instance with `REG_LIMIT` = 0 shows the same stimulus falling through to the width cause instead of the register cause.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_REG   = 3'd1,
    CAUSE_ROB   = 3'd2,
    CAUSE_SCHED = 3'd3,
    CAUSE_LQ    = 3'd4,
    CAUSE_SQ    = 3'd5,
    CAUSE_GROUP = 3'd6
  } stall_cause_e;

  localparam int NUM_CAUSES = 6;

  function automatic int pick_width(input int cfg, input int dflt);
    return (cfg == 0) ? dflt : cfg;
  endfunction

  function automatic int cnt_bits(input int depth);
    return (depth < 1) ? 1 : $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/dsp_credit.sv
module dsp_credit #(
  parameter int DEPTH = 4,
  parameter int FW    = 3,
  parameter int SUM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUM_W-1:0] take,
  input  logic [FW-1:0]    give,
  output logic [FW-1:0]    free_cnt
);

  logic [FW-1:0]    free_q;
  logic [FW-1:0]    free_d;
  logic [SUM_W-1:0] sum;
  logic             upd_en;

  always_comb begin
    sum    = SUM_W'(free_q) - take + SUM_W'(give);
    free_d = sum[FW-1:0];
    upd_en = (take != '0) || (give != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= FW'(DEPTH);
    end else if (upd_en) begin
      free_q <= free_d;
    end
  end

  assign free_cnt = free_q;

endmodule

// File: rtl/dsp_admit.sv
module dsp_admit import dsp_pkg::*; #(
  parameter int LANES     = 2,
  parameter int UOP_W     = 2,
  parameter int DST_W     = 2,
  parameter int NUM_SCHED = 2,
  parameter int SCH_IDW   = 1,
  parameter int WIDTH     = 2,
  parameter bit REG_UNB   = 1'b0,
  parameter int ROB_FW    = 3,
  parameter int REG_FW    = 3,
  parameter int SCH_FW    = 2,
  parameter int LQ_FW     = 2,
  parameter int SQ_FW     = 1,
  parameter int SUM_W     = 16
) (
  input  logic [LANES-1:0]            in_valid,
  input  logic [LANES*UOP_W-1:0]      in_uops,
  input  logic [LANES*DST_W-1:0]      in_dsts,
  input  logic [LANES*SCH_IDW-1:0]    in_sched,
  input  logic [LANES-1:0]            in_load,
  input  logic [LANES-1:0]            in_store,
  input  logic [ROB_FW-1:0]           rob_free,
  input  logic [REG_FW-1:0]           reg_free,
  input  logic [NUM_SCHED*SCH_FW-1:0] sch_free,
  input  logic [LQ_FW-1:0]            lq_free,
  input  logic [SQ_FW-1:0]            sq_free,
  output logic [LANES-1:0]            grant,
  output logic [SUM_W-1:0]            take_rob,
  output logic [SUM_W-1:0]            take_reg,
  output logic [NUM_SCHED*SUM_W-1:0]  take_sch,
  output logic [SUM_W-1:0]            take_lq,
  output logic [SUM_W-1:0]            take_sq,
  output stall_cause_e                cause
);

  logic [SUM_W-1:0] a_u, a_d, a_l, a_s;
  logic [SUM_W-1:0] a_sch [NUM_SCHED];
  logic [SUM_W-1:0] u, d;
  logic             alive;
  logic             ok_reg, ok_rob, ok_sch, ok_lq, ok_sq, ok_w;
  int               sid;

  always_comb begin
    alive = 1'b1;
    cause = CAUSE_NONE;
    grant = '0;
    a_u   = '0;
    a_d   = '0;
    a_l   = '0;
    a_s   = '0;
    u     = '0;
    d     = '0;
    sid   = 0;
    ok_reg = 1'b0;
    ok_rob = 1'b0;
    ok_sch = 1'b0;
    ok_lq  = 1'b0;
    ok_sq  = 1'b0;
    ok_w   = 1'b0;
    for (int s = 0; s < NUM_SCHED; s++) a_sch[s] = '0;
    for (int i = 0; i < LANES; i++) begin
      u   = SUM_W'(in_uops[i*UOP_W +: UOP_W]);
      d   = SUM_W'(in_dsts[i*DST_W +: DST_W]);
      sid = int'(in_sched[i*SCH_IDW +: SCH_IDW]);
      if (sid >= NUM_SCHED) sid = 0;
      ok_reg = REG_UNB ? 1'b1 : ((a_d + d) <= SUM_W'(reg_free));
      ok_rob = (a_u + u) <= SUM_W'(rob_free);
      ok_sch = (a_sch[sid] + SUM_W'(1)) <= SUM_W'(sch_free[sid*SCH_FW +: SCH_FW]);
      ok_lq  = !in_load[i]  || ((a_l + SUM_W'(1)) <= SUM_W'(lq_free));
      ok_sq  = !in_store[i] || ((a_s + SUM_W'(1)) <= SUM_W'(sq_free));
      ok_w   = (a_u == '0) || ((a_u + u) <= SUM_W'(WIDTH));
      if (alive && in_valid[i]) begin
        if (ok_reg && ok_rob && ok_sch && ok_lq && ok_sq && ok_w) begin
          grant[i]   = 1'b1;
          a_u        = a_u + u;
          a_d        = a_d + d;
          a_sch[sid] = a_sch[sid] + SUM_W'(1);
          if (in_load[i])  a_l = a_l + SUM_W'(1);
          if (in_store[i]) a_s = a_s + SUM_W'(1);
        end else begin
          alive = 1'b0;
          if      (!ok_reg) cause = CAUSE_REG;
          else if (!ok_rob) cause = CAUSE_ROB;
          else if (!ok_sch) cause = CAUSE_SCHED;
          else if (!ok_lq)  cause = CAUSE_LQ;
          else if (!ok_sq)  cause = CAUSE_SQ;
          else              cause = CAUSE_GROUP;
        end
      end else begin
        alive = 1'b0;
      end
    end
    take_rob = a_u;
    take_reg = REG_UNB ? '0 : a_d;
    take_lq  = a_l;
    take_sq  = a_s;
    for (int s = 0; s < NUM_SCHED; s++) take_sch[s*SUM_W +: SUM_W] = a_sch[s];
  end

endmodule

// File: rtl/dsp_stats.sv
module dsp_stats import dsp_pkg::*; #(
  parameter int LANES = 2,
  parameter int CNT_W = 16,
  parameter int SUM_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  stall_cause_e                cause,
  input  logic [SUM_W-1:0]            grp_uops,
  output logic [NUM_CAUSES*CNT_W-1:0] stall_flat,
  output logic [(LANES+1)*CNT_W-1:0]  hist_flat
);

  localparam int NBINS = LANES + 1;

  logic [CNT_W-1:0] stall_q [NUM_CAUSES];
  logic [CNT_W-1:0] stall_d [NUM_CAUSES];
  logic [CNT_W-1:0] hist_q  [NBINS];
  logic [CNT_W-1:0] hist_d  [NBINS];
  logic             stall_en;
  logic             hist_en;
  int               bin;

  always_comb begin
    bin      = (grp_uops > SUM_W'(LANES)) ? LANES : int'(grp_uops);
    stall_en = (cause != CAUSE_NONE);
    hist_en  = 1'b1;
    for (int c = 0; c < NUM_CAUSES; c++) begin
      stall_d[c] = stall_q[c] + CNT_W'(int'(cause) == (c + 1));
    end
    for (int b = 0; b < NBINS; b++) begin
      hist_d[b] = hist_q[b] + CNT_W'(b == bin);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CAUSES; c++) stall_q[c] <= '0;
      for (int b = 0; b < NBINS; b++)      hist_q[b]  <= '0;
    end else begin
      if (stall_en) begin
        for (int c = 0; c < NUM_CAUSES; c++) stall_q[c] <= stall_d[c];
      end
      if (hist_en) begin
        for (int b = 0; b < NBINS; b++) hist_q[b] <= hist_d[b];
      end
    end
  end

  for (genvar c = 0; c < NUM_CAUSES; c++) begin : g_stall_out
    assign stall_flat[c*CNT_W +: CNT_W] = stall_q[c];
  end
  for (genvar b = 0; b < NBINS; b++) begin : g_hist_out
    assign hist_flat[b*CNT_W +: CNT_W] = hist_q[b];
  end

endmodule

// File: rtl/dispatch_stage.sv
module dispatch_stage import dsp_pkg::*; #(
  parameter int DISP_W      = 0,
  parameter int DEF_W       = 2,
  parameter int UOP_W       = 2,
  parameter int DST_W       = 2,
  parameter int NUM_SCHED   = 2,
  parameter int ROB_DEPTH   = 6,
  parameter int REG_LIMIT   = 4,
  parameter int SCHED_DEPTH = 2,
  parameter int LQ_DEPTH    = 2,
  parameter int SQ_DEPTH    = 1,
  parameter int CNT_W       = 16,
  localparam int LANES      = pick_width(DISP_W, DEF_W),
  localparam int SCH_IDW    = (NUM_SCHED > 1) ? $clog2(NUM_SCHED) : 1,
  localparam int ROB_FW     = cnt_bits(ROB_DEPTH),
  localparam int REG_FW     = cnt_bits((REG_LIMIT == 0) ? 1 : REG_LIMIT)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LANES-1:0]           in_valid,
  input  logic [LANES*UOP_W-1:0]     in_uops,
  input  logic [LANES*DST_W-1:0]     in_dsts,
  input  logic [LANES*SCH_IDW-1:0]   in_sched,
  input  logic [LANES-1:0]           in_load,
  input  logic [LANES-1:0]           in_store,
  input  logic [ROB_FW-1:0]          rob_release,
  input  logic [REG_FW-1:0]          reg_release,
  input  logic [NUM_SCHED-1:0]       sched_release,
  input  logic                       lq_release,
  input  logic                       sq_release,
  output logic [LANES-1:0]           disp_valid,
  output logic [CNT_W-1:0]           stall_reg_cnt,
  output logic [CNT_W-1:0]           stall_rob_cnt,
  output logic [CNT_W-1:0]           stall_sched_cnt,
  output logic [CNT_W-1:0]           stall_lq_cnt,
  output logic [CNT_W-1:0]           stall_sq_cnt,
  output logic [CNT_W-1:0]           stall_group_cnt,
  output logic [(LANES+1)*CNT_W-1:0] hist_cnt
);

  localparam int  SCH_FW  = cnt_bits(SCHED_DEPTH);
  localparam int  LQ_FW   = cnt_bits(LQ_DEPTH);
  localparam int  SQ_FW   = cnt_bits(SQ_DEPTH);
  localparam int  SUM_W   = 16;
  localparam bit  REG_UNB = (REG_LIMIT == 0);

  logic [ROB_FW-1:0]           rob_free;
  logic [REG_FW-1:0]           reg_free;
  logic [NUM_SCHED*SCH_FW-1:0] sch_free;
  logic [LQ_FW-1:0]            lq_free;
  logic [SQ_FW-1:0]            sq_free;
  logic [LANES-1:0]            grant;
  logic [SUM_W-1:0]            take_rob;
  logic [SUM_W-1:0]            take_reg;
  logic [NUM_SCHED*SUM_W-1:0]  take_sch;
  logic [SUM_W-1:0]            take_lq;
  logic [SUM_W-1:0]            take_sq;
  stall_cause_e                cause;
  logic [NUM_CAUSES*CNT_W-1:0] stall_flat;
  logic [(LANES+1)*CNT_W-1:0]  hist_flat;

  dsp_admit #(
    .LANES(LANES), .UOP_W(UOP_W), .DST_W(DST_W), .NUM_SCHED(NUM_SCHED),
    .SCH_IDW(SCH_IDW), .WIDTH(LANES), .REG_UNB(REG_UNB), .ROB_FW(ROB_FW),
    .REG_FW(REG_FW), .SCH_FW(SCH_FW), .LQ_FW(LQ_FW), .SQ_FW(SQ_FW), .SUM_W(SUM_W)
  ) u_admit (
    .in_valid(in_valid), .in_uops(in_uops), .in_dsts(in_dsts), .in_sched(in_sched),
    .in_load(in_load), .in_store(in_store), .rob_free(rob_free), .reg_free(reg_free),
    .sch_free(sch_free), .lq_free(lq_free), .sq_free(sq_free), .grant(grant),
    .take_rob(take_rob), .take_reg(take_reg), .take_sch(take_sch),
    .take_lq(take_lq), .take_sq(take_sq), .cause(cause)
  );

  dsp_credit #(.DEPTH(ROB_DEPTH), .FW(ROB_FW), .SUM_W(SUM_W)) u_rob (
    .clk(clk), .rst_n(rst_n), .take(take_rob), .give(rob_release), .free_cnt(rob_free)
  );

  if (REG_UNB) begin : g_reg_unbounded
    assign reg_free = '0;
  end else begin : g_reg_pool
    dsp_credit #(.DEPTH(REG_LIMIT), .FW(REG_FW), .SUM_W(SUM_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .take(take_reg), .give(reg_release), .free_cnt(reg_free)
    );
  end

  for (genvar s = 0; s < NUM_SCHED; s++) begin : g_sched
    dsp_credit #(.DEPTH(SCHED_DEPTH), .FW(SCH_FW), .SUM_W(SUM_W)) u_sch (
      .clk(clk), .rst_n(rst_n), .take(take_sch[s*SUM_W +: SUM_W]),
      .give(SCH_FW'(sched_release[s])), .free_cnt(sch_free[s*SCH_FW +: SCH_FW])
    );
  end

  dsp_credit #(.DEPTH(LQ_DEPTH), .FW(LQ_FW), .SUM_W(SUM_W)) u_lq (
    .clk(clk), .rst_n(rst_n), .take(take_lq), .give(LQ_FW'(lq_release)), .free_cnt(lq_free)
  );

  dsp_credit #(.DEPTH(SQ_DEPTH), .FW(SQ_FW), .SUM_W(SUM_W)) u_sq (
    .clk(clk), .rst_n(rst_n), .take(take_sq), .give(SQ_FW'(sq_release)), .free_cnt(sq_free)
  );

  dsp_stats #(.LANES(LANES), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .cause(cause), .grp_uops(take_rob),
    .stall_flat(stall_flat), .hist_flat(hist_flat)
  );

  assign disp_valid      = grant;
  assign stall_reg_cnt   = stall_flat[0*CNT_W +: CNT_W];
  assign stall_rob_cnt   = stall_flat[1*CNT_W +: CNT_W];
  assign stall_sched_cnt = stall_flat[2*CNT_W +: CNT_W];
  assign stall_lq_cnt    = stall_flat[3*CNT_W +: CNT_W];
  assign stall_sq_cnt    = stall_flat[4*CNT_W +: CNT_W];
  assign stall_group_cnt = stall_flat[5*CNT_W +: CNT_W];
  assign hist_cnt        = hist_flat;

endmodule

// File: rtl/dispatch_stage_chk.sv
module dispatch_stage_chk #(
  parameter int LANES       = 2,
  parameter int UOP_W       = 2,
  parameter int WIDTH       = 2,
  parameter int ROB_DEPTH   = 6,
  parameter int ROB_FW      = 3,
  parameter int NUM_SCHED   = 2,
  parameter int SCH_FW      = 2,
  parameter int SCHED_DEPTH = 2,
  parameter int CNT_W       = 16,
  parameter int NC          = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [LANES-1:0]            in_valid,
  input logic [LANES*UOP_W-1:0]      in_uops,
  input logic [LANES-1:0]            disp_valid,
  input logic [ROB_FW-1:0]           rob_free,
  input logic [NUM_SCHED*SCH_FW-1:0] sch_free,
  input logic [NC*CNT_W-1:0]         stall_flat,
  input logic [(LANES+1)*CNT_W-1:0]  hist_flat
);

  logic [NC*CNT_W-1:0]        stall_prev;
  logic [(LANES+1)*CNT_W-1:0] hist_prev;
  logic                       past_ok;
  logic [NC-1:0]              stall_chg;
  logic [LANES:0]             hist_chg;
  int                         grant_uops;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok    <= 1'b0;
      stall_prev <= '0;
      hist_prev  <= '0;
    end else begin
      past_ok    <= 1'b1;
      stall_prev <= stall_flat;
      hist_prev  <= hist_flat;
    end
  end

  always_comb begin
    grant_uops = 0;
    for (int i = 0; i < LANES; i++) begin
      if (disp_valid[i]) grant_uops = grant_uops + int'(in_uops[i*UOP_W +: UOP_W]);
    end
    for (int c = 0; c < NC; c++) stall_chg[c] = stall_flat[c*CNT_W +: CNT_W] != stall_prev[c*CNT_W +: CNT_W];
    for (int b = 0; b <= LANES; b++) hist_chg[b] = hist_flat[b*CNT_W +: CNT_W] != hist_prev[b*CNT_W +: CNT_W];
  end

  p_prefix_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((disp_valid + LANES'(1)) & disp_valid) == '0);

  p_grant_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid & ~in_valid) == '0);

  p_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_uops > WIDTH) |-> (disp_valid == LANES'(1)));

  p_rob_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rob_free <= ROB_FW'(ROB_DEPTH));

  for (genvar s = 0; s < NUM_SCHED; s++) begin : g_sch_chk
    p_sched_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sch_free[s*SCH_FW +: SCH_FW] <= SCH_FW'(SCHED_DEPTH));
  end

  p_one_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> $onehot0(stall_chg));

  p_hist_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ($countones(hist_chg) == 1));

endmodule

bind dispatch_stage dispatch_stage_chk #(
  .LANES(LANES), .UOP_W(UOP_W), .WIDTH(LANES), .ROB_DEPTH(ROB_DEPTH),
  .ROB_FW(ROB_FW), .NUM_SCHED(NUM_SCHED), .SCH_FW(SCH_FW),
  .SCHED_DEPTH(SCHED_DEPTH), .CNT_W(CNT_W), .NC(6)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops),
  .disp_valid(disp_valid), .rob_free(rob_free), .sch_free(sch_free),
  .stall_flat(stall_flat), .hist_flat(hist_flat)
);

// File: tb/dispatch_stage_bench.sv
module dispatch_stage_bench;

  logic clk;
  logic rst_n;
  int   total;
  int   bad;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] in_valid, in_sched, in_load, in_store;
  logic [3:0] in_uops, in_dsts;
  logic [2:0] rob_rel, reg_rel;
  logic [1:0] sch_rel;
  logic       lq_rel, sq_rel;
  logic [2:0] u_rob_rel;
  logic [0:0] u_reg_rel;
  logic [1:0] u_sch_rel;
  logic       u_lq_rel, u_sq_rel;

  logic [1:0]  dv, dv_u;
  logic [15:0] s_reg, s_rob, s_sch, s_lq, s_sq, s_grp;
  logic [15:0] su_reg, su_rob, su_sch, su_lq, su_sq, su_grp;
  logic [47:0] hist, hist_u;

  assign u_rob_rel = '0;
  assign u_reg_rel = '0;
  assign u_sch_rel = '0;
  assign u_lq_rel  = 1'b0;
  assign u_sq_rel  = 1'b0;

  dispatch_stage u_dispatch_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops), .in_dsts(in_dsts),
    .in_sched(in_sched), .in_load(in_load), .in_store(in_store),
    .rob_release(rob_rel), .reg_release(reg_rel), .sched_release(sch_rel),
    .lq_release(lq_rel), .sq_release(sq_rel), .disp_valid(dv),
    .stall_reg_cnt(s_reg), .stall_rob_cnt(s_rob), .stall_sched_cnt(s_sch),
    .stall_lq_cnt(s_lq), .stall_sq_cnt(s_sq), .stall_group_cnt(s_grp), .hist_cnt(hist)
  );

  dispatch_stage #(.REG_LIMIT(0)) u_dispatch_stage_unb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops), .in_dsts(in_dsts),
    .in_sched(in_sched), .in_load(in_load), .in_store(in_store),
    .rob_release(u_rob_rel), .reg_release(u_reg_rel), .sched_release(u_sch_rel),
    .lq_release(u_lq_rel), .sq_release(u_sq_rel), .disp_valid(dv_u),
    .stall_reg_cnt(su_reg), .stall_rob_cnt(su_rob), .stall_sched_cnt(su_sch),
    .stall_lq_cnt(su_lq), .stall_sq_cnt(su_sq), .stall_group_cnt(su_grp), .hist_cnt(hist_u)
  );

  // stimulus per lane
  int v[2], u[2], d[2], s[2], ld[2], st[2];
  // model pools
  int m_rob, m_reg, m_lq, m_sq;
  int m_sch[2];
  int exp_stall[6];
  int exp_hist[3];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive();
    in_valid = {v[1][0], v[0][0]};
    in_uops  = {u[1][1:0], u[0][1:0]};
    in_dsts  = {d[1][1:0], d[0][1:0]};
    in_sched = {s[1][0], s[0][0]};
    in_load  = {ld[1][0], ld[0][0]};
    in_store = {st[1][0], st[0][0]};
  endtask

  task automatic idle();
    for (int i = 0; i < 2; i++) begin
      v[i] = 0; u[i] = 1; d[i] = 0; s[i] = 0; ld[i] = 0; st[i] = 0;
    end
    drive();
    rob_rel = '0; reg_rel = '0; sch_rel = '0; lq_rel = 1'b0; sq_rel = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic model_step(output int gmask, output int cause, output int gu,
                            output int gd, output int gl, output int gs, output int gsch0,
                            output int gsch1);
    int asch[2];
    bit alive;
    bit oreg, orob, osch, olq, osq, ow;
    alive = 1'b1; gmask = 0; cause = 0; gu = 0; gd = 0; gl = 0; gs = 0;
    asch[0] = 0; asch[1] = 0;
    for (int i = 0; i < 2; i++) begin
      if (!alive || v[i] == 0) begin
        alive = 1'b0;
      end else begin
        oreg = (gd + d[i]) <= m_reg;
        orob = (gu + u[i]) <= m_rob;
        osch = (asch[s[i]] + 1) <= m_sch[s[i]];
        olq  = (ld[i] == 0) || ((gl + 1) <= m_lq);
        osq  = (st[i] == 0) || ((gs + 1) <= m_sq);
        ow   = (gu == 0) || ((gu + u[i]) <= 2);
        if (oreg && orob && osch && olq && osq && ow) begin
          gmask = gmask | (1 << i);
          gu = gu + u[i]; gd = gd + d[i]; asch[s[i]] = asch[s[i]] + 1;
          gl = gl + ld[i]; gs = gs + st[i];
        end else begin
          alive = 1'b0;
          cause = !oreg ? 1 : !orob ? 2 : !osch ? 3 : !olq ? 4 : !osq ? 5 : 6;
        end
      end
    end
    gsch0 = asch[0];
    gsch1 = asch[1];
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int gm, cz, gu, gd, gl, gs, g0, g1;
    int rr, gr, r0, r1, lr, sr;
    total = 0;
    bad   = 0;

    // R11: reset state
    do_reset();
    #1;
    check(s_reg == 0 && s_rob == 0 && s_sch == 0, "R11 stall counters after reset", int'(s_reg + s_rob + s_sch), 0);
    check(s_lq == 0 && s_sq == 0 && s_grp == 0, "R11 queue/group counters after reset", int'(s_lq + s_sq + s_grp), 0);
    check(hist == '0, "R11 histogram after reset", int'(hist[15:0] + hist[31:16] + hist[47:32]), 0);

    // R8: oversize instruction dispatches alone at the head of an empty group
    do_reset();
    @(negedge clk);
    v[0] = 1; u[0] = 3; d[0] = 0; s[0] = 0;
    v[1] = 1; u[1] = 1; d[1] = 0; s[1] = 1;
    drive();
    #3;
    check(dv == 2'b01, "R8 oversize head granted alone", int'(dv), 1);
    @(negedge clk);
    idle();
    #1;
    check(s_grp == 1, "R8 R9 width stall charged", int'(s_grp), 1);
    check(hist[32 +: 16] == 1, "R10 oversize saturates to top bin", int'(hist[32 +: 16]), 1);
    check(hist[0 +: 16] == 1, "R10 idle cycle in bin 0", int'(hist[0 +: 16]), 1);

    // R9 priority: register shortage outranks width; R4 unbounded instance
    do_reset();
    @(negedge clk);
    v[0] = 1; u[0] = 2; d[0] = 3; s[0] = 0;
    v[1] = 1; u[1] = 1; d[1] = 2; s[1] = 1;
    drive();
    #3;
    check(dv == 2'b01, "R4 register-limited grant", int'(dv), 1);
    check(dv_u == 2'b01, "R2 width-limited grant unbounded", int'(dv_u), 1);
    @(negedge clk);
    idle();
    #1;
    check(s_reg == 1 && s_grp == 0, "R9 register cause ranks above width", int'(s_reg), 1);
    check(su_reg == 0 && su_grp == 1, "R4 unbounded registers never block", int'(su_grp), 1);
    check(hist[32 +: 16] == 1, "R10 two-uop group bin", int'(hist[32 +: 16]), 1);

    // R7: a single store fills the 1-entry store queue; release usable next cycle
    do_reset();
    @(negedge clk);
    v[0] = 1; u[0] = 1; st[0] = 1; v[1] = 1; u[1] = 1; st[1] = 1; s[1] = 1;
    drive();
    #3;
    check(dv == 2'b01, "R6 second store blocked in same group", int'(dv), 1);
    @(negedge clk);
    v[1] = 0; drive(); sq_rel = 1'b1;
    #3;
    check(dv == 2'b00, "R7 release not usable in its own cycle", int'(dv), 0);
    @(negedge clk);
    sq_rel = 1'b0;
    #3;
    check(dv == 2'b01, "R7 release usable next cycle", int'(dv), 1);
    @(negedge clk);
    idle();
    #1;
    check(s_sq == 2, "R9 store queue stalls counted", int'(s_sq), 2);

    // Randomized sweep against the model
    do_reset();
    m_rob = 6; m_reg = 4; m_lq = 2; m_sq = 1; m_sch[0] = 2; m_sch[1] = 2;
    for (int c = 0; c < 6; c++) exp_stall[c] = 0;
    exp_hist[0] = 1; exp_hist[1] = 0; exp_hist[2] = 0;
    for (int cyc = 0; cyc < 5000; cyc++) begin
      @(negedge clk);
      v[0] = ($urandom_range(0, 9) < 8) ? 1 : 0;
      v[1] = (v[0] == 1 && $urandom_range(0, 9) < 7) ? 1 : 0;
      for (int i = 0; i < 2; i++) begin
        u[i]  = $urandom_range(1, 3);
        d[i]  = $urandom_range(0, 3);
        s[i]  = $urandom_range(0, 1);
        ld[i] = ($urandom_range(0, 9) < 3) ? 1 : 0;
        st[i] = ($urandom_range(0, 9) < 2) ? 1 : 0;
      end
      drive();
      rr = $urandom_range(0, imin(2, 6 - m_rob));
      gr = $urandom_range(0, imin(2, 4 - m_reg));
      r0 = (m_sch[0] < 2) ? $urandom_range(0, 1) : 0;
      r1 = (m_sch[1] < 2) ? $urandom_range(0, 1) : 0;
      lr = (m_lq < 2) ? $urandom_range(0, 1) : 0;
      sr = (m_sq < 1 && $urandom_range(0, 2) == 0) ? 1 : 0;
      rob_rel = 3'(rr); reg_rel = 3'(gr); sch_rel = {r1[0], r0[0]};
      lq_rel = lr[0]; sq_rel = sr[0];
      #3;
      model_step(gm, cz, gu, gd, gl, gs, g0, g1);
      check(int'(dv) == gm, "R1 R2 R3 R4 R5 R6 R7 grant prefix", int'(dv), gm);
      m_rob = m_rob - gu + rr;
      m_reg = m_reg - gd + gr;
      m_sch[0] = m_sch[0] - g0 + r0;
      m_sch[1] = m_sch[1] - g1 + r1;
      m_lq = m_lq - gl + lr;
      m_sq = m_sq - gs + sr;
      if (cz > 0) exp_stall[cz-1]++;
      exp_hist[imin(gu, 2)]++;
    end
    @(negedge clk);
    idle();
    #1;
    check(int'(s_reg) == exp_stall[0], "R9 register stall count", int'(s_reg), exp_stall[0]);
    check(int'(s_rob) == exp_stall[1], "R9 reorder stall count", int'(s_rob), exp_stall[1]);
    check(int'(s_sch) == exp_stall[2], "R9 scheduler stall count", int'(s_sch), exp_stall[2]);
    check(int'(s_lq) == exp_stall[3], "R9 load queue stall count", int'(s_lq), exp_stall[3]);
    check(int'(s_sq) == exp_stall[4], "R9 store queue stall count", int'(s_sq), exp_stall[4]);
    check(int'(s_grp) == exp_stall[5], "R9 width stall count", int'(s_grp), exp_stall[5]);
    for (int b = 0; b < 3; b++) begin
      check(int'(hist[b*16 +: 16]) == exp_hist[b], "R10 histogram bin", int'(hist[b*16 +: 16]), exp_hist[b]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule